// File: doc/BRIEF.md
# CAN Mailbox FIFO Window

This block sits between a CPU register bus and a CAN protocol engine. It holds two four-deep frame queues: one for transmit and one for receive. Software never addresses the queue entries directly. Each queue is seen through one fixed mailbox window, which is four words wide: identifier, length code, low data word and high data word. The transmit window is mailbox slot 56, at word addresses 224 to 227. The receive window is mailbox slot 60, at word addresses 240 to 243. Data byte 0 sits in bits 7:0 of the low data word.

To send a frame, software stages it in the transmit window and then writes 0xFF to the transmit pointer register. That write commits the staged frame and moves the CPU-side write pointer on. The engine side sees the oldest queued frame on `tx_valid`/`tx_*` and retires it with `tx_done`. Received frames enter through `rx_valid`. Software reads the oldest one from the receive window and releases it by writing 0xFF to the receive pointer register.

Two status bits flag queue events: bit 3 for transmit and bit 4 for receive. A per-bit enable gates each of them onto a single `irq` line. Register word addresses are:

| Address | Register |
|---------|----------|
| 1 | transmit control |
| 2 | transmit pointer |
| 3 | receive control |
| 4 | receive pointer |
| 5 | interrupt enable |
| 6 | interrupt status |

Top module: `can_mbx_window`

## Requirements
- R1: After reset, the following values hold:
  - transmit control (addr 1) reads 0;
  - receive control (addr 3) reads 0x80, meaning empty and disabled;
  - interrupt status (addr 6) reads 0;
  - `irq`, `tx_valid` and `rx_overrun` are 0.
- R2: The identifier word crosses the block unaltered in both directions. Bit 31 flags an extended ID and bit 30 flags a remote request. A standard 11-bit ID occupies bits 28:18 and an extended ID occupies bits 28:0. The staged transmit window reads back as written, with the length code kept to bits 3:0.
- R3: A write of 0xFF (low byte) to addr 2 appends the staged frame to the transmit queue. It does so only while transmit is enabled (addr 1 bit 0) and fewer than 4 frames are queued. The unsent count in addr 1 bits 3:1 then rises by one.
- R4: A transmit pointer write is ignored in any of three cases: the value is other than 0xFF, transmit is disabled, or the queue is full. The unsent count does not change.
- R5: While transmit is enabled and the queue is non-empty, `tx_valid` is 1 and `tx_*` show the oldest committed frame. A `tx_done` pulse retires that frame, lowers the unsent count and sets status bit 3. A `tx_done` pulse while `tx_valid` is 0 has no effect.
- R6: A frame on `rx_valid` is queued when receive is enabled (addr 3 bit 0) and the queue is not full. Status bit 4 is then set. Addr 3 bit 7 reads 0 while any frame is queued. The receive window shows the oldest frame and reads 0 when the queue is empty.
- R7: A write of 0xFF to addr 4 releases the oldest receive frame, and the next one appears in the window. Any other value is ignored. A release while the queue is empty is ignored.
- R8: A frame arriving while receive is enabled and the queue is full is dropped. `rx_overrun` is 1 in that cycle, and the four queued frames stay intact and in order.
- R9: Writing addr 6 clears each status bit written as 0 and leaves each bit written as 1 unchanged. A write never sets a status bit.
- R10: `irq` is the OR of the status bits (3 and 4) whose enable bits at addr 5 are 1.
- R11: While receive is disabled, incoming frames are neither queued nor flagged as overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_addr | input | 8 | register word address |
| bus_wr | input | 1 | write strobe, one word per cycle |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for bus_addr, combinational |
| tx_valid | output | 1 | a committed frame waits at the transmit head |
| tx_id | output | 32 | head frame identifier word |
| tx_dlc | output | 4 | head frame length code |
| tx_data | output | 64 | head frame data bytes, byte 0 in bits 7:0 |
| tx_done | input | 1 | engine has sent the head frame |
| rx_valid | input | 1 | a received frame is offered this cycle |
| rx_id | input | 32 | received identifier word |
| rx_dlc | input | 4 | received length code |
| rx_data | input | 64 | received data bytes |
| rx_overrun | output | 1 | offered frame dropped because the queue is full |
| irq | output | 1 | interrupt request |

## Verification
The in-design properties take for granted that `tx_done` and `rx_valid` are single-cycle strobes. They also assume that at most one register write occurs per cycle, and that `rst_n` deasserts only after the two-stage release has settled. The bench drives every input on the falling clock edge and pulses each strobe for exactly one cycle. It keeps register writes one at a time, so queue pushes and pops meet the properties' view of legal traffic. The bench sweeps the transmit and receive queues from empty through full and beyond. Expected counts are computed as min(commits, 4), and frame contents are derived arithmetically from each frame index.

// File: rtl/can_mbx_pkg.sv
package can_mbx_pkg;

  typedef struct packed {
    logic [31:0] id;
    logic [3:0]  dlc;
    logic [63:0] data;
  } can_frame_t;

  // register word addresses
  localparam int unsigned REG_TX_CTL = 1;
  localparam int unsigned REG_TX_PTR = 2;
  localparam int unsigned REG_RX_CTL = 3;
  localparam int unsigned REG_RX_PTR = 4;
  localparam int unsigned REG_IRQ_EN = 5;
  localparam int unsigned REG_IRQ_ST = 6;

  // status / enable bit positions
  localparam int unsigned IRQ_TX_BIT = 3;
  localparam int unsigned IRQ_RX_BIT = 4;

  localparam logic [7:0] PTR_ADVANCE = 8'hFF;

endpackage

// File: rtl/can_frame_queue.sv
module can_frame_queue
  import can_mbx_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  can_frame_t                   push_frame,
  input  logic                         pop,
  output can_frame_t                   head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  can_frame_t       slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    ptr_inc = (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) wr_ptr_d = ptr_inc(wr_ptr_q);
    if (pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage: no reset, written only under push
  always_ff @(posedge clk) begin
    if (push) slot_q[wr_ptr_q] <= push_frame;
  end

  assign head  = slot_q[rd_ptr_q];
  assign count = cnt_q;
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R3
  count_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + CNT_W'(1)));

  // R5
  count_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (count == $past(count) - CNT_W'(1)));

endmodule

// File: rtl/can_irq_ctl.sv
module can_irq_ctl #(
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic             st_wr,
  input  logic             en_wr,
  input  logic [N_SRC-1:0] wbits,
  output logic [N_SRC-1:0] status,
  output logic [N_SRC-1:0] enable,
  output logic             irq
);

  logic [N_SRC-1:0] st_q, st_d;
  logic [N_SRC-1:0] en_q, en_d;

  for (genvar j = 0; j < N_SRC; j++) begin : g_src
    always_comb begin
      if (evt[j])                   st_d[j] = 1'b1;
      else if (st_wr && !wbits[j])  st_d[j] = 1'b0;
      else                          st_d[j] = st_q[j];
      en_d[j] = en_wr ? wbits[j] : en_q[j];
    end

    // R9
    st_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && !wbits[j] && !evt[j]) |=> !status[j]);

    // R9
    st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt[j] && !status[j]) |=> !status[j]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= st_d;
      en_q <= en_d;
    end
  end

  assign status = st_q;
  assign enable = en_q;
  assign irq    = |(st_q & en_q);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);

endmodule

// File: rtl/can_mbx_window.sv
module can_mbx_window
  import can_mbx_pkg::*;
#(
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned TX_WIN_SLOT = 56,
  parameter int unsigned RX_WIN_SLOT = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_valid,
  output logic [31:0] tx_id,
  output logic [3:0]  tx_dlc,
  output logic [63:0] tx_data,
  input  logic        tx_done,
  input  logic        rx_valid,
  input  logic [31:0] rx_id,
  input  logic [3:0]  rx_dlc,
  input  logic [63:0] rx_data,
  output logic        rx_overrun,
  output logic        irq
);

  localparam int unsigned CNT_W   = $clog2(DEPTH + 1);
  localparam int unsigned WIN_W   = 4;
  localparam int unsigned TX_BASE = TX_WIN_SLOT * WIN_W;
  localparam int unsigned RX_BASE = RX_WIN_SLOT * WIN_W;
  localparam int unsigned A_W     = (ADDR_W < 8) ? ADDR_W : 8;

  // ---------------- reset: async assert, sync release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // ---------------- address decode
  logic [A_W-1:0] addr;
  assign addr = bus_addr[A_W-1:0];

  function automatic logic hit(input logic [A_W-1:0] a, input int unsigned r);
    hit = (a == A_W'(r));
  endfunction

  logic wr_txctl, wr_txptr, wr_rxctl, wr_rxptr, wr_ien, wr_ist;
  logic [WIN_W-1:0] wr_txwin;
  logic ptr_code;

  assign ptr_code = (bus_wdata[7:0] == PTR_ADVANCE);
  assign wr_txctl = bus_wr && hit(addr, REG_TX_CTL);
  assign wr_txptr = bus_wr && hit(addr, REG_TX_PTR);
  assign wr_rxctl = bus_wr && hit(addr, REG_RX_CTL);
  assign wr_rxptr = bus_wr && hit(addr, REG_RX_PTR);
  assign wr_ien   = bus_wr && hit(addr, REG_IRQ_EN);
  assign wr_ist   = bus_wr && hit(addr, REG_IRQ_ST);

  for (genvar w = 0; w < WIN_W; w++) begin : g_txwin_dec
    assign wr_txwin[w] = bus_wr && hit(addr, TX_BASE + w);
  end

  // ---------------- enables and staging window
  logic       txe_q, txe_d, rxe_q, rxe_d;
  can_frame_t stage_q, stage_d;
  logic       stage_en;

  always_comb begin
    txe_d    = wr_txctl ? bus_wdata[0] : txe_q;
    rxe_d    = wr_rxctl ? bus_wdata[0] : rxe_q;
    stage_d  = stage_q;
    stage_en = |wr_txwin;
    if (wr_txwin[0]) stage_d.id          = bus_wdata;
    if (wr_txwin[1]) stage_d.dlc         = bus_wdata[3:0];
    if (wr_txwin[2]) stage_d.data[31:0]  = bus_wdata;
    if (wr_txwin[3]) stage_d.data[63:32] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      txe_q <= 1'b0;
      rxe_q <= 1'b0;
    end else begin
      txe_q <= txe_d;
      rxe_q <= rxe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    stage_q <= '0;
    else if (stage_en) stage_q <= stage_d;
  end

  // ---------------- transmit queue
  can_frame_t       tx_head;
  logic [CNT_W-1:0] tx_count;
  logic             tx_empty, tx_full, tx_push, tx_pop;

  assign tx_push  = wr_txptr && ptr_code && txe_q && !tx_full;
  assign tx_valid = txe_q && !tx_empty;
  assign tx_pop   = tx_valid && tx_done;

  can_frame_queue #(.DEPTH(DEPTH)) u_txq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .push       (tx_push),
    .push_frame (stage_q),
    .pop        (tx_pop),
    .head       (tx_head),
    .count      (tx_count),
    .empty      (tx_empty),
    .full       (tx_full)
  );

  assign tx_id   = tx_head.id;
  assign tx_dlc  = tx_head.dlc;
  assign tx_data = tx_head.data;

  // ---------------- receive queue
  can_frame_t       rx_in, rx_head;
  logic [CNT_W-1:0] rx_count;
  logic             rx_empty, rx_full, rx_push, rx_pop;

  assign rx_in      = '{id: rx_id, dlc: rx_dlc, data: rx_data};
  assign rx_push    = rx_valid && rxe_q && !rx_full;
  assign rx_overrun = rx_valid && rxe_q && rx_full;
  assign rx_pop     = wr_rxptr && ptr_code && !rx_empty;

  can_frame_queue #(.DEPTH(DEPTH)) u_rxq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .push       (rx_push),
    .push_frame (rx_in),
    .pop        (rx_pop),
    .head       (rx_head),
    .count      (rx_count),
    .empty      (rx_empty),
    .full       (rx_full)
  );

  // ---------------- interrupts: index 0 = transmit, 1 = receive
  logic [1:0] irq_st, irq_en;

  can_irq_ctl #(.N_SRC(2)) u_irq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .evt    ({rx_push, tx_pop}),
    .st_wr  (wr_ist),
    .en_wr  (wr_ien),
    .wbits  ({bus_wdata[IRQ_RX_BIT], bus_wdata[IRQ_TX_BIT]}),
    .status (irq_st),
    .enable (irq_en),
    .irq    (irq)
  );

  // ---------------- read mux
  always_comb begin
    bus_rdata = '0;
    if (hit(addr, REG_TX_CTL)) begin
      bus_rdata[0]       = txe_q;
      bus_rdata[CNT_W:1] = tx_count;
    end else if (hit(addr, REG_RX_CTL)) begin
      bus_rdata[0] = rxe_q;
      bus_rdata[7] = rx_empty;
    end else if (hit(addr, REG_IRQ_EN)) begin
      bus_rdata[IRQ_TX_BIT] = irq_en[0];
      bus_rdata[IRQ_RX_BIT] = irq_en[1];
    end else if (hit(addr, REG_IRQ_ST)) begin
      bus_rdata[IRQ_TX_BIT] = irq_st[0];
      bus_rdata[IRQ_RX_BIT] = irq_st[1];
    end else if (hit(addr, TX_BASE + 0)) bus_rdata = stage_q.id;
    else if (hit(addr, TX_BASE + 1))     bus_rdata = {28'd0, stage_q.dlc};
    else if (hit(addr, TX_BASE + 2))     bus_rdata = stage_q.data[31:0];
    else if (hit(addr, TX_BASE + 3))     bus_rdata = stage_q.data[63:32];
    else if (!rx_empty) begin
      if      (hit(addr, RX_BASE + 0)) bus_rdata = rx_head.id;
      else if (hit(addr, RX_BASE + 1)) bus_rdata = {28'd0, rx_head.dlc};
      else if (hit(addr, RX_BASE + 2)) bus_rdata = rx_head.data[31:0];
      else if (hit(addr, RX_BASE + 3)) bus_rdata = rx_head.data[63:32];
    end
  end

  // R5
  tx_event_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_valid && tx_done) |=> irq_st[0]);

  // R6
  rx_event_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_push |=> (irq_st[1] && !rx_empty));

  // R8
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_overrun && !rx_pop) |=> $stable(rx_count));

  // R11
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rxe_q |-> !rx_overrun);

  // R4
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!txe_q && !tx_done) |=> $stable(tx_count));

endmodule

// File: tb/tb_can_mbx_window.sv
`timescale 1ns/1ps
module tb_can_mbx_window;

  localparam int TXC = 1, TXP = 2, RXC = 3, RXP = 4, IEN = 5, IST = 6;
  localparam int TXW = 224, RXW = 240;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid;
  logic [31:0] tx_id;
  logic [3:0]  tx_dlc;
  logic [63:0] tx_data;
  logic        tx_done = 1'b0;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_id = '0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic        rx_overrun;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_mbx_window dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
    .tx_id(tx_id), .tx_dlc(tx_dlc), .tx_data(tx_data), .tx_done(tx_done),
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_dlc(rx_dlc), .rx_data(rx_data),
    .rx_overrun(rx_overrun), .irq(irq)
  );

  // frame k: standard data, extended data, or standard remote-request
  function automatic logic [31:0] f_id(input int k);
    case (k % 3)
      0:       f_id = 32'((k * 37 + 5) & 32'h7FF) << 18;
      1:       f_id = 32'h8000_0000 | ((32'(k) * 32'h0012_3457) & 32'h1FFF_FFFF);
      default: f_id = 32'h4000_0000 | (32'((k * 11) & 32'h7FF) << 18);
    endcase
  endfunction
  function automatic logic [3:0]  f_dlc(input int k); f_dlc = 4'((k * 3 + 1) % 9); endfunction
  function automatic logic [31:0] f_lo(input int k);  f_lo  = 32'hA500_0000 + 32'(k * 257); endfunction
  function automatic logic [31:0] f_hi(input int k);  f_hi  = ~f_lo(k) ^ 32'(k); endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 8'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 8'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic stage(input int k);
    wr(TXW + 0, f_id(k));
    wr(TXW + 1, 32'(f_dlc(k)));
    wr(TXW + 2, f_lo(k));
    wr(TXW + 3, f_hi(k));
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic offer(input int k, output logic ovr);
    @(negedge clk);
    rx_valid = 1'b1; rx_id = f_id(k); rx_dlc = f_dlc(k);
    rx_data = {f_hi(k), f_lo(k)};
    #1 ovr = rx_overrun;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic chk_rx_head(input string tag, input int k);
    logic [31:0] d;
    rd(RXW + 0, d); chk(tag, d, f_id(k));
    rd(RXW + 1, d); chk(tag, d, 32'(f_dlc(k)));
    rd(RXW + 2, d); chk(tag, d, f_lo(k));
    rd(RXW + 3, d); chk(tag, d, f_hi(k));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic ovr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(TXC, d); chk("R1 txctl", d, 0);
    rd(RXC, d); chk("R1 rxctl", d, 32'h80);
    rd(IST, d); chk("R1 status", d, 0);
    chk("R1 outputs", {irq, tx_valid, rx_overrun}, 0);

    wr(TXC, 1); wr(RXC, 1); wr(IEN, 32'h18);

    // R3/R4 commit sweep 0..5 frames, count saturates at 4
    for (int k = 0; k < 6; k++) begin
      stage(k);
      if (k == 1) begin
        // R2 staged window readback
        rd(TXW + 0, d); chk("R2 stage id", d, f_id(1));
        rd(TXW + 1, d); chk("R2 stage dlc", d, 32'(f_dlc(1)));
      end
      wr(TXP, 32'hFF);
      rd(TXC, d);
      chk((k < 4) ? "R3 unsent" : "R4 full ignore", d, 32'(((k + 1 < 4 ? k + 1 : 4) << 1) | 1));
    end
    rd(IST, d); chk("R5 no event before send", d, 0);

    // R5 drain in order
    for (int j = 0; j < 4; j++) begin
      #1;
      chk("R5 tx_valid", tx_valid, 1);
      chk("R2 R5 tx head", {tx_id, tx_dlc}, {f_id(j), f_dlc(j)});
      chk("R5 tx data", tx_data, {f_hi(j), f_lo(j)});
      pulse_done();
      rd(TXC, d); chk("R5 unsent drop", d, 32'(((3 - j) << 1) | 1));
      rd(IST, d); chk("R5 tx event", d[3], 1);
      if (j == 0) begin
        wr(TXP, 32'h7F);
        rd(TXC, d); chk("R4 non-FF ignore", d, 32'((3 << 1) | 1));
      end
    end
    #1 chk("R5 empty not valid", tx_valid, 0);
    chk("R10 irq tx", irq, 1);
    wr(IST, 32'h10);
    rd(IST, d); chk("R9 clear bit3", d, 0);
    chk("R10 irq low", irq, 0);
    pulse_done();
    rd(IST, d); chk("R5 done while idle", d, 0);
    rd(TXC, d); chk("R5 done while idle cnt", d, 1);
    wr(TXC, 0); wr(TXP, 32'hFF);
    rd(TXC, d); chk("R4 disabled ignore", d, 0);
    #1 chk("R4 disabled valid", tx_valid, 0);

    // R6/R8 receive fill past full
    rd(RXC, d); chk("R6 empty flag", d, 32'h81);
    rd(RXW, d); chk("R6 empty window", d, 0);
    for (int k = 10; k < 15; k++) begin
      offer(k, ovr);
      chk((k == 14) ? "R8 overrun" : "R6 no overrun", ovr, (k == 14));
    end
    rd(RXC, d); chk("R6 nonempty flag", d, 32'h01);
    rd(IST, d); chk("R6 rx event", d, 32'h10);
    chk("R10 irq rx", irq, 1);
    wr(RXP, 32'h00);
    chk_rx_head("R7 non-FF ignore", 10);
    for (int j = 0; j < 4; j++) begin
      chk_rx_head("R8 R6 rx order", 10 + j);
      wr(RXP, 32'hFF);
    end
    rd(RXC, d); chk("R7 drained", d, 32'h81);
    wr(RXP, 32'hFF);
    offer(20, ovr);
    chk_rx_head("R7 empty release ignored", 20);
    wr(RXP, 32'hFF);
    rd(RXC, d); chk("R7 release last", d, 32'h81);

    // R10 gating, R9 write-one no effect
    wr(IEN, 0);
    #1 chk("R10 gated off", irq, 0);
    wr(IEN, 32'h10);
    #1 chk("R10 gated on", irq, 1);
    wr(IST, 32'h08);
    rd(IST, d); chk("R9 clear bit4", d, 0);
    wr(IST, 32'h18);
    rd(IST, d); chk("R9 write one no set", d, 0);

    // R11 receive disabled
    wr(RXC, 0);
    offer(30, ovr);
    chk("R11 no overrun", ovr, 0);
    rd(RXC, d); chk("R11 not queued", d, 32'h80);
    rd(IST, d); chk("R11 no event", d, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule